// File: doc/BRIEF.md
# Interrupt Vector Dispatch Unit

This block chooses the next program counter for a small microcontroller core with an 11-bit program address. Five peripheral events can raise requests: two comparator outputs, two timer/event-counter overflows and an A/D end-of-conversion. Each event sets a pending flag. A pending request is serviced only when all of the following hold:

- its own enable is set;
- the global interrupt enable is set;
- the hardware return stack still has room.

When a request is serviced, the block drives that source's vector as the next program counter. In the same cycle it raises a one-cycle push request that carries the sequential return address.

Each cycle is treated as an instruction boundary. When no request is serviced, the next program counter is the sequential address supplied by the core. While reset is held, the next program counter is the initialization address 000H. Taking a vector clears the global enable. A return-from-interrupt pulse sets it again, so requests that arrive during a service routine wait until the routine ends.

Top module: `irq_vector_sel`

## Requirements
- R1: While `rst_n` is low, `next_pc_o` is 000H and `push_o` is 0. After reset, with no events, `next_pc_o` equals `seq_pc_i` and `push_o` stays 0.
- R2: An event pulse on `evt_i[k]` is latched on the clock edge. In the following cycle, if the request is eligible, `push_o` is 1, `next_pc_o` is the vector and `push_addr_o` equals `seq_pc_i`.
- R3: The vector for bit k of `evt_i` is 4*(k+1). Bit 0 (comparator 0) maps to 004H, bit 1 (comparator 1) to 008H, bit 2 (timer 0) to 00CH, bit 3 (timer 1) to 010H and bit 4 (A/D done) to 014H.
- R4: A pending request whose `irq_en_i` bit is 0 is not serviced but stays pending. It is serviced in the cycle its enable bit becomes 1.
- R5: When `stack_level_i` equals STACK_DEPTH (stack full), no vector is taken and the request stays pending. It is serviced once the level drops.
- R6: The global enable is 1 after reset. It is cleared when a vector is taken and set again by a one-cycle `ret_i` pulse. While it is clear, no vector is taken.
- R7: When several eligible requests are pending, the lowest bit index (lowest vector address) is serviced first.
- R8: The serviced source's pending flag is cleared on the edge that ends the vector cycle. An event on that same source in that same cycle is kept pending.
- R9: `push_o` is high for exactly one cycle for each vector taken.
- R10: A request that arrives while the global enable is clear is latched. It is serviced in the cycle after `ret_i` restores the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | N_SRC | One-cycle event pulses from peripherals |
| irq_en_i | input | N_SRC | Per-source interrupt enables |
| stack_level_i | input | LVL_W | Current return stack occupancy |
| ret_i | input | 1 | Return-from-interrupt pulse; sets global enable |
| seq_pc_i | input | PC_W | Sequential next address from the core |
| next_pc_o | output | PC_W | Selected next program counter |
| push_o | output | 1 | Return stack push strobe |
| push_addr_o | output | PC_W | Return address to push |

## Verification
Two situations are hard to reach from the ports. The first is an event on a source in the very cycle that the same source is being serviced. The bench reaches it by waiting for the vector cycle and then driving the same event bit before the next edge. It then shows that the flag survived by returning from the interrupt and seeing the vector taken again. The second is a request held back by a full stack or a disabled source. Because the pending state is not visible at the ports, the bench checks it by releasing the blocking condition and seeing the vector appear with no new event.

// File: rtl/irq_vector_sel.sv
module irq_vector_sel #(
  parameter int PC_W        = 11,
  parameter int N_SRC       = 5,
  parameter int VEC_STEP    = 4,
  parameter int STACK_DEPTH = 8,
  localparam int LVL_W      = $clog2(STACK_DEPTH + 1),
  localparam int IDX_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] irq_en_i,
  input  logic [LVL_W-1:0] stack_level_i,
  input  logic             ret_i,
  input  logic [PC_W-1:0]  seq_pc_i,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             push_o,
  output logic [PC_W-1:0]  push_addr_o
);

  logic [N_SRC-1:0] pend_q;
  logic             gie_q;
  logic [N_SRC-1:0] elig;
  logic [IDX_W-1:0] sel;
  logic             stack_full;
  logic             take;
  logic [PC_W-1:0]  vec_addr;
  logic [N_SRC-1:0] svc_mask;

  assign elig       = pend_q & irq_en_i;
  assign stack_full = (stack_level_i >= LVL_W'(STACK_DEPTH));
  assign take       = rst_n && gie_q && (|elig) && !stack_full;

  always_comb begin
    sel = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (elig[i]) sel = IDX_W'(i);
  end

  assign vec_addr = (PC_W'(sel) + PC_W'(1)) * PC_W'(VEC_STEP);
  assign svc_mask = take ? (N_SRC'(1) << sel) : '0;

  assign next_pc_o   = !rst_n ? '0 : (take ? vec_addr : seq_pc_i);
  assign push_o      = take;
  assign push_addr_o = seq_pc_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      gie_q  <= 1'b1;
    end else begin
      pend_q <= (pend_q & ~svc_mask) | evt_i;
      if (take)       gie_q <= 1'b0;
      else if (ret_i) gie_q <= 1'b1;
    end
  end

  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    stack_full |-> !push_o);  // R5
  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> !push_o);  // R9
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> (next_pc_o[1:0] == 2'b00 && next_pc_o != '0
                && next_pc_o <= PC_W'(N_SRC * VEC_STEP)));  // R3
  AST_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> ((pend_q & irq_en_i) != '0));  // R4
  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && evt_i == '0) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));  // R8
  AST_MASKED_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o ##1 !ret_i) |=> !push_o);  // R6

endmodule

// File: tb/irq_vector_sel_tb_top.sv
module irq_vector_sel_tb_top;
  localparam int PC_W = 11, N_SRC = 5, DEPTH = 8;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, ret_i = 0;
  logic [N_SRC-1:0] evt_i = '0, irq_en_i = '1;
  logic [LVL_W-1:0] stack_level_i = '0;
  logic [PC_W-1:0] seq_pc_i = 11'h123;
  logic [PC_W-1:0] next_pc_o, push_addr_o;
  logic push_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_vector_sel #(.PC_W(PC_W), .N_SRC(N_SRC), .STACK_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .irq_en_i(irq_en_i),
    .stack_level_i(stack_level_i), .ret_i(ret_i), .seq_pc_i(seq_pc_i),
    .next_pc_o(next_pc_o), .push_o(push_o), .push_addr_o(push_addr_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse_evt(input logic [N_SRC-1:0] m);
    evt_i = m; step(); evt_i = '0;
  endtask

  task automatic do_ret();
    ret_i = 1; step(); ret_i = 0;
  endtask

  task automatic expect_vec(input int v, input string req);
    chk(push_o === 1'b1, req, push_o, 1);
    chk(next_pc_o == PC_W'(v), req, next_pc_o, v);
  endtask

  task automatic t_reset();
    #1;
    chk(next_pc_o == '0, "R1", next_pc_o, 0);
    chk(push_o == 0, "R1", push_o, 0);
    step(); step();
    rst_n = 1; step();
    chk(next_pc_o == seq_pc_i, "R1", next_pc_o, seq_pc_i);
    chk(push_o == 0, "R1", push_o, 0);
  endtask

  task automatic t_vectors();
    for (int k = 0; k < N_SRC; k++) begin
      seq_pc_i = PC_W'(11'h200 + k);
      pulse_evt(N_SRC'(1) << k);
      expect_vec(4 * (k + 1), "R3");
      chk(push_addr_o == seq_pc_i, "R2", push_addr_o, seq_pc_i);
      step();
      chk(push_o == 0, "R9", push_o, 0);
      chk(next_pc_o == seq_pc_i, "R6", next_pc_o, seq_pc_i);
      do_ret();
      chk(push_o == 0, "R8", push_o, 0);
    end
  endtask

  task automatic t_enable();
    irq_en_i = 5'b11011;
    pulse_evt(5'b00100);
    chk(push_o == 0, "R4", push_o, 0);
    step(); step();
    chk(push_o == 0, "R4", push_o, 0);
    irq_en_i = '1; #1;
    expect_vec(12'h00C, "R4");
    step(); do_ret();
  endtask

  task automatic t_full();
    stack_level_i = LVL_W'(DEPTH);
    pulse_evt(5'b00010);
    chk(push_o == 0, "R5", push_o, 0);
    step(); step();
    chk(push_o == 0, "R5", push_o, 0);
    stack_level_i = LVL_W'(DEPTH - 1); #1;
    expect_vec(12'h008, "R5");
    step(); do_ret();
    stack_level_i = '0;
  endtask

  task automatic t_prio();
    pulse_evt(5'b11010);
    expect_vec(12'h008, "R7");
    step(); do_ret();
    expect_vec(12'h010, "R7");
    step(); do_ret();
    expect_vec(12'h014, "R7");
    step(); do_ret();
    chk(push_o == 0, "R7", push_o, 0);
  endtask

  task automatic t_nested();
    pulse_evt(5'b00001);
    expect_vec(12'h004, "R10");
    step();
    pulse_evt(5'b10000);
    chk(push_o == 0, "R10", push_o, 0);
    step();
    chk(push_o == 0, "R6", push_o, 0);
    do_ret();
    expect_vec(12'h014, "R10");
    step(); do_ret();
  endtask

  task automatic t_same_cycle();
    pulse_evt(5'b00001);
    expect_vec(12'h004, "R8");
    evt_i = 5'b00001; step(); evt_i = '0;
    chk(push_o == 0, "R9", push_o, 0);
    do_ret();
    expect_vec(12'h004, "R8");
    step(); do_ret();
    chk(push_o == 0, "R8", push_o, 0);
  endtask

  initial begin
    t_reset();
    t_vectors();
    t_enable();
    t_full();
    t_prio();
    t_nested();
    t_same_cycle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule